// File: doc/BRIEF.md
# Scanline Sprite Selector

This unit decides which sprites take part in drawing one scanline. A start pulse hands it a line number and a height mode. It then walks a table of sprite vertical positions, one entry per clock, from index 0 upward. It reads the table through a simple address/data pair: it drives an address and expects the Y value back in the same cycle. Each sprite whose vertical span covers the requested line is recorded in the next free slot of an eight-slot list. Because the walk is in index order, the lowest-numbered sprites win.

The walk stops at one of three points: after the last table entry, on reaching an end-of-list marker value, or when a ninth covering sprite turns up. A ninth covering sprite raises a sticky overflow flag, which a separate clear input resets. When the walk stops, a done flag rises and the list and count stay frozen until the next accepted start. Fetching pattern data, horizontal placement and pixel mixing are handled elsewhere.

Top module: `sprite_line_select`

## Requirements
- R1: While reset is applied and after it is released, with no start given: busy_o, done_o and ovf_o are 0 and sel_cnt_o is 0.
- R2: A sprite with position Y covers line L when (L - Y - 1) mod 256 is less than the height. The height is 8 when tall_i is 0 and 16 when tall_i is 1. tall_i and line_i are sampled when a start is accepted.
- R3: Covering sprites are stored in ascending index order. Slot k occupies sel_idx_o bits [6k+5:6k], and slot 0 holds the lowest index. sel_cnt_o gives the number of filled slots.
- R4: At most eight sprites are kept. Finding a ninth covering sprite sets ovf_o, ends the scan, and leaves the first eight in the list.
- R5: A table value of 208 ends the scan at that entry. Neither that entry nor any later entry is selected.
- R6: The table entries are visited one per clock. ytab_addr_o equals the entry index and steps by one each cycle while busy_o is 1. done_o rises exactly E clocks after the start is accepted, where E is the number of entries visited, including the entry that ended the scan.
- R7: ovf_o stays set across later scans until ovf_clr_i is applied. If an overflow and a clear fall in the same cycle, the overflow wins.
- R8: A start pulse that arrives while busy_o is 1 is ignored, and the scan in progress finishes with its original line and mode.
- R9: When a start is accepted, all slots read zero. After done_o rises, sel_idx_o, sel_cnt_o and done_o hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Begins a scan when the unit is not busy |
| line_i | input | 8 | Scanline to be matched |
| tall_i | input | 1 | Sprite height select: 0 gives 8 lines, 1 gives 16 lines |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| ytab_addr_o | output | 6 | Index of the sprite table entry being read |
| ytab_y_i | input | 8 | Y value of the addressed entry, valid in the same cycle |
| sel_idx_o | output | 48 | Eight 6-bit slots of selected sprite indices |
| sel_cnt_o | output | 4 | Number of filled slots, 0 to 8 |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Scan finished; the list is valid |
| ovf_o | output | 1 | Sticky flag: more than eight sprites covered a line |

## Verification
The overflow set and the overflow clear can fall in the same cycle. The bench holds ovf_clr_i high for the whole length of a scan that finds nine covering sprites. It then expects ovf_o to read 1 when done_o rises. It also expects a clear applied while the unit is idle to drop the flag on the next clock. A second same-cycle case is a start that arrives mid-scan: the result must match a scan done without that pulse.

// File: rtl/sprite_line_select_pkg.sv
package sprite_line_select_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/sprite_span_match.sv
module sprite_span_match #(
  parameter int YW      = 8,
  parameter int SHORT_H = 8,
  parameter int TALL_H  = 16
) (
  input  logic [YW-1:0] line_i,
  input  logic [YW-1:0] y_i,
  input  logic          tall_i,
  output logic          hit_o
);
  logic [YW-1:0] offset;
  logic [YW-1:0] height;

  // row offset within the sprite, wrapping modulo 2^YW
  assign offset = line_i - y_i - YW'(1);
  assign height = tall_i ? YW'(TALL_H) : YW'(SHORT_H);
  assign hit_o  = offset < height;
endmodule

// File: rtl/sprite_slot_bank.sv
module sprite_slot_bank #(
  parameter int N_SEL = 8,
  parameter int IW    = 6,
  parameter int CW    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               wr_i,
  input  logic [CW-1:0]      wr_ptr_i,
  input  logic [IW-1:0]      wr_idx_i,
  output logic [N_SEL*IW-1:0] slots_o
);
  for (genvar s = 0; s < N_SEL; s++) begin : g_slot
    logic [IW-1:0] slot_q, slot_d;
    logic          slot_en;

    assign slot_en = clr_i | (wr_i & (wr_ptr_i == CW'(s)));

    always_comb begin
      slot_d = slot_q;
      if (clr_i) slot_d = '0;
      else if (slot_en) slot_d = wr_idx_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else if (slot_en) slot_q <= slot_d;
    end

    assign slots_o[s*IW +: IW] = slot_q;
  end
endmodule

// File: rtl/sprite_scan_ctrl.sv
module sprite_scan_ctrl
  import sprite_line_select_pkg::*;
#(
  parameter int N_SPR = 64,
  parameter int N_SEL = 8,
  parameter int IW    = 6,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          hit_i,
  input  logic          term_i,
  input  logic          ovf_clr_i,
  output logic [IW-1:0] idx_o,
  output logic [CW-1:0] cnt_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          ovf_o,
  output logic          accept_o,
  output logic          store_o
);
  scan_state_e   state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          ovf_q, ovf_d;
  logic          scanning, full, ovf_hit, last, finish;

  assign scanning = (state_q == ST_SCAN);
  assign full     = (cnt_q == CW'(N_SEL));
  assign accept_o = (state_q == ST_IDLE) & start_i;
  // the end marker is looked at before the coverage result
  assign store_o  = scanning & ~term_i & hit_i & ~full;
  assign ovf_hit  = scanning & ~term_i & hit_i & full;
  assign last     = (idx_q == IW'(N_SPR - 1));
  assign finish   = scanning & (term_i | ovf_hit | last);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    if (accept_o) begin
      state_d = ST_SCAN;
      idx_d   = '0;
      cnt_d   = '0;
      done_d  = 1'b0;
    end else if (scanning) begin
      if (store_o) cnt_d = cnt_q + CW'(1);
      if (finish) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end else begin
        idx_d = idx_q + IW'(1);
      end
    end
  end

  // an overflow found in the same cycle as a clear takes precedence
  always_comb begin
    ovf_d = ovf_q;
    if (ovf_hit) ovf_d = 1'b1;
    else if (ovf_clr_i) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      ovf_q   <= ovf_d;
    end
  end

  assign idx_o  = idx_q;
  assign cnt_o  = cnt_q;
  assign busy_o = scanning;
  assign done_o = done_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/sprite_line_select.sv
module sprite_line_select #(
  parameter int N_SPR   = 64,
  parameter int N_SEL   = 8,
  parameter int YW      = 8,
  parameter int END_Y   = 208,
  parameter int SHORT_H = 8,
  parameter int TALL_H  = 16,
  localparam int IW     = $clog2(N_SPR),
  localparam int CW     = $clog2(N_SEL + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [YW-1:0]       line_i,
  input  logic                tall_i,
  input  logic                ovf_clr_i,
  output logic [IW-1:0]       ytab_addr_o,
  input  logic [YW-1:0]       ytab_y_i,
  output logic [N_SEL*IW-1:0] sel_idx_o,
  output logic [CW-1:0]       sel_cnt_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                ovf_o
);
  logic          rst_meta_q, rst_sync_q;
  logic [YW-1:0] line_q;
  logic          tall_q;
  logic          hit, term, accept, store;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      line_q <= '0;
      tall_q <= 1'b0;
    end else if (accept) begin
      line_q <= line_i;
      tall_q <= tall_i;
    end
  end

  assign term = (ytab_y_i == YW'(END_Y));

  sprite_span_match #(
    .YW(YW), .SHORT_H(SHORT_H), .TALL_H(TALL_H)
  ) u_match (
    .line_i (line_q),
    .y_i    (ytab_y_i),
    .tall_i (tall_q),
    .hit_o  (hit)
  );

  sprite_scan_ctrl #(
    .N_SPR(N_SPR), .N_SEL(N_SEL), .IW(IW), .CW(CW)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .start_i   (start_i),
    .hit_i     (hit),
    .term_i    (term),
    .ovf_clr_i (ovf_clr_i),
    .idx_o     (idx),
    .cnt_o     (cnt),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .ovf_o     (ovf_o),
    .accept_o  (accept),
    .store_o   (store)
  );

  sprite_slot_bank #(
    .N_SEL(N_SEL), .IW(IW), .CW(CW)
  ) u_slots (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .clr_i    (accept),
    .wr_i     (store),
    .wr_ptr_i (cnt),
    .wr_idx_i (idx),
    .slots_o  (sel_idx_o)
  );

  assign ytab_addr_o = idx;
  assign sel_cnt_o   = cnt;
endmodule

// File: rtl/sprite_line_select_chk.sv
module sprite_line_select_chk #(
  parameter int N_SEL = 8,
  parameter int IW    = 6,
  parameter int CW    = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                ovf_clr_i,
  input logic [IW-1:0]       ytab_addr_o,
  input logic [N_SEL*IW-1:0] sel_idx_o,
  input logic [CW-1:0]       sel_cnt_o,
  input logic                busy_o,
  input logic                done_o,
  input logic                ovf_o
);
  // R4
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_cnt_o <= CW'(N_SEL));

  // R4
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> sel_cnt_o == CW'(N_SEL));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> ytab_addr_o == IW'($past(ytab_addr_o) + IW'(1)));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy_o));

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o && !done_o && sel_cnt_o == '0 && sel_idx_o == '0);

  // R9
  hold_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o && $stable(sel_idx_o) && $stable(sel_cnt_o));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o && !ovf_clr_i |=> ovf_o);

  // R7
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr_i && !busy_o |=> !ovf_o);
endmodule

bind sprite_line_select sprite_line_select_chk #(
  .N_SEL(N_SEL), .IW(IW), .CW(CW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .ovf_clr_i   (ovf_clr_i),
  .ytab_addr_o (ytab_addr_o),
  .sel_idx_o   (sel_idx_o),
  .sel_cnt_o   (sel_cnt_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .ovf_o       (ovf_o)
);

// File: tb/tb_sprite_line_select.sv
module tb_sprite_line_select;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  line_i = '0;
  logic        tall_i = 1'b0;
  logic        ovf_clr_i = 1'b0;
  logic [5:0]  ytab_addr_o;
  logic [7:0]  ytab_y_i;
  logic [47:0] sel_idx_o;
  logic [3:0]  sel_cnt_o;
  logic        busy_o, done_o, ovf_o;

  logic [7:0] ytab [64];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic exp_ovf = 1'b0;
  int exp_sel [8];
  int exp_cnt, exp_e;
  logic exp_hit9;

  always #4 clk = ~clk;

  assign ytab_y_i = ytab[ytab_addr_o];

  sprite_line_select dut (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog: act=%0d exp<=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic bit covers(logic [7:0] ln, logic [7:0] y, logic tall);
    logic [7:0] off;
    off = ln - y - 8'd1;
    return off < (tall ? 8'd16 : 8'd8);
  endfunction

  task automatic model(logic [7:0] ln, logic tall);
    exp_cnt = 0;
    exp_e = 0;
    exp_hit9 = 1'b0;
    for (int k = 0; k < 8; k++) exp_sel[k] = 0;
    for (int i = 0; i < 64; i++) begin
      exp_e++;
      if (ytab[i] == 8'd208) break;
      if (covers(ln, ytab[i], tall)) begin
        if (exp_cnt == 8) begin
          exp_hit9 = 1'b1;
          break;
        end
        exp_sel[exp_cnt] = i;
        exp_cnt++;
      end
    end
  endtask

  task automatic run_scan(logic [7:0] ln, logic tall, bit hold_clr, bit poke);
    int n;
    model(ln, tall);
    @(negedge clk);
    line_i = ln;
    tall_i = tall;
    start_i = 1'b1;
    ovf_clr_i = hold_clr;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    line_i = ~ln;
    tall_i = ~tall;
    n = 0;
    while (!done_o && n < 200) begin
      if (poke && n == 2) start_i = 1'b1;
      @(posedge clk);
      n++;
      @(negedge clk);
      start_i = 1'b0;
    end
    if (hold_clr) exp_ovf = 1'b0;
    if (exp_hit9) exp_ovf = 1'b1;
    // R6 visit count and done timing
    chk("R6 cycles", n, exp_e);
    chk("R3 count", int'(sel_cnt_o), exp_cnt);
    for (int k = 0; k < 8; k++)
      chk("R3 slot", int'(sel_idx_o[k*6 +: 6]), exp_sel[k]);
    chk("R7 ovf", int'(ovf_o), int'(exp_ovf));
    ovf_clr_i = 1'b0;
  endtask

  task automatic clear_ovf();
    @(negedge clk);
    ovf_clr_i = 1'b1;
    @(negedge clk);
    ovf_clr_i = 1'b0;
    exp_ovf = 1'b0;
    chk("R7 clear", int'(ovf_o), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) ytab[i] = 8'd240;
    repeat (2) @(negedge clk);
    // R1 during reset
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ovf", int'(ovf_o), 0);
    chk("R1 count", int'(sel_cnt_o), 0);
    chk("R1 busy idle", int'(busy_o), 0);

    // R4: every entry covers, overflow at the ninth
    for (int i = 0; i < 64; i++) ytab[i] = 8'd45;
    run_scan(8'd50, 1'b0, 1'b0, 1'b0);
    chk("R4 ovf set", int'(ovf_o), 1);
    // R7: sticky across a scan with no hits
    for (int i = 0; i < 64; i++) ytab[i] = 8'd100;
    run_scan(8'd10, 1'b0, 1'b0, 1'b0);
    chk("R7 sticky", int'(ovf_o), 1);
    clear_ovf();

    // R5: end marker at index 3, covering entries after it
    for (int i = 0; i < 64; i++) ytab[i] = 8'd45;
    ytab[3] = 8'd208;
    run_scan(8'd50, 1'b0, 1'b0, 1'b0);
    chk("R5 count", int'(sel_cnt_o), 3);

    // R2: offset 12 covers only in tall mode
    for (int i = 0; i < 64; i++) ytab[i] = (i % 5 == 0) ? 8'd87 : 8'd150;
    run_scan(8'd100, 1'b0, 1'b0, 1'b0);
    chk("R2 short", int'(sel_cnt_o), 0);
    run_scan(8'd100, 1'b1, 1'b0, 1'b0);
    chk("R2 tall", int'(sel_cnt_o), 8);

    // R2: wrap modulo 256
    for (int i = 0; i < 64; i++) ytab[i] = 8'd120;
    ytab[7] = 8'd250;
    ytab[9] = 8'd254;
    run_scan(8'd3, 1'b0, 1'b0, 1'b0);
    chk("R2 wrap short", int'(sel_cnt_o), 1);
    run_scan(8'd3, 1'b1, 1'b0, 1'b0);
    chk("R2 wrap tall", int'(sel_cnt_o), 2);

    // R8: start while busy is ignored
    for (int i = 0; i < 64; i++) ytab[i] = (i % 9 == 4) ? 8'd60 : 8'd30;
    run_scan(8'd64, 1'b0, 1'b0, 1'b1);

    // R9: list holds while idle
    begin
      logic [47:0] keep;
      keep = sel_idx_o;
      repeat (10) @(negedge clk);
      chk("R9 hold", int'(sel_idx_o == keep), 1);
      chk("R9 done", int'(done_o), 1);
    end

    // R7: clear held through an overflowing scan, set wins
    for (int i = 0; i < 64; i++) ytab[i] = 8'd45;
    run_scan(8'd50, 1'b0, 1'b1, 1'b0);
    chk("R7 set wins", int'(ovf_o), 1);
    clear_ovf();

    // random scans around the target line
    for (int t = 0; t < 300; t++) begin
      logic [7:0] ln;
      logic tl;
      ln = 8'($urandom);
      tl = 1'($urandom);
      for (int i = 0; i < 64; i++) begin
        int r;
        r = $urandom % 100;
        if (r < 2) ytab[i] = 8'd208;
        else if (r < 40) ytab[i] = ln - 8'd1 - 8'($urandom % 20);
        else ytab[i] = 8'($urandom);
      end
      run_scan(ln, tl, ($urandom % 8) == 0, ($urandom % 10) == 0);
      if (($urandom % 4) == 0) clear_ovf();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule